// File: doc/BRIEF.md
# Frame-Buffered Pulse Width Modulator

This block produces one pulse-width-modulated output from an 8-bit frame counter. A simple register write port programs four settings: the frame length, the pulse width, an output polarity flag and a 4-bit clock-rate exponent. A run flag in the same control byte starts and halts the waveform. The input clock is divided by a power of two to form a one-cycle tick, and each tick advances the frame counter. A frame lasts (frame length + 1) ticks.

Writes to the frame length and the pulse width go to holding registers first. The counter takes in the new values only when the frame in progress wraps, so a frame is never built from a mix of old and new settings. While the run flag is clear, the output rests high and the holding values feed straight through. When the run flag rises, the counter therefore starts at zero with whatever was last written.

A stop input freezes the waveform at whatever phase it has reached, and the waveform carries on from that phase once stop is released. A wait input is accepted but changes nothing.

Top module: `shadow_pwm`

## Requirements
- R1: After synchronous reset the output is high, the frame length register holds 0xFF, the pulse width register holds 0x00, and the run flag, the polarity flag and the rate exponent are all 0.
- R2: While running, one frame lasts (frame length + 1) ticks, with the counter stepping 0, 1, ..., frame length and then back to 0.
- R3: While the counter is below the pulse width, the output sits at its active level; for the rest of the frame it sits at its inactive level. A pulse width of 0 keeps the output inactive for the whole frame. A pulse width above the frame length keeps it active for the whole frame.
- R4: The polarity flag is control bit 1. When it is 0 the active level is low and the inactive level is high. When it is 1 both levels are swapped.
- R5: While the run flag (control bit 0) is 0, the output is high, whatever the polarity flag holds.
- R6: The rate exponent N is control bits 7:4. Each counter step lasts 2^N input clock cycles.
- R7: A write to the frame length (address 2) or the pulse width (address 1) takes effect only from the first frame that starts after the write. The frame in progress completes with the old values.
- R8: When the run flag rises (control byte at address 0), the counter starts from 0 with the frame length and pulse width most recently written. Address 3 is ignored.
- R9: While stop_i is high, the counter and the prescaler hold and the output does not change. After stop_i falls, the waveform continues from the same phase.
- R10: wait_i has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 pulse width, 2 frame length |
| wr_data | input | 8 | Write data |
| wait_i | input | 1 | Low-power wait request, ignored |
| stop_i | input | 1 | Freeze request |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions take wr_addr, stop_i and wait_i to be synchronous to clk and free of unknown values once reset is released. The tick-spacing property also takes the rate exponent to stay fixed between two ticks, unless software has just rewritten it. The stimulus drives every input on the falling edge, changes the rate only while the run flag is clear, and changes frame settings during a run only through the normal write port. This lets the frame-boundary properties see only legal update patterns.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
    localparam int DATA_W = 8;
    localparam int RATE_W = 4;
    localparam int ADDR_W = 2;
    localparam int DIV_W  = (1 << RATE_W) - 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_WIDTH  = 2'd1,
        SEL_FRAME  = 2'd2,
        SEL_UNUSED = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              pol;
        logic              run;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.rate = d[7:4];
        c.pol  = d[1];
        c.run  = d[0];
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++) begin
            m[i] = (i < int'(r));
        end
        return m;
    endfunction
endpackage

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
    import shadow_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] width_q,
    output logic [DATA_W-1:0] frame_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            width_q <= '0;
            frame_q <= '1;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_CTRL:  ctrl    <= decode_ctrl(wr_data);
                SEL_WIDTH: width_q <= wr_data;
                SEL_FRAME: frame_q <= wr_data;
                default:   ;
            endcase
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == '0 && width_q == '0 && frame_q == '1)); // R1
endmodule

// File: rtl/shadow_pwm_prescaler.sv
module shadow_pwm_prescaler
    import shadow_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              hold,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = rate_mask(rate);
    assign tick = run && !hold && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (!hold) begin
            div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && rate != '0) |=> (!tick || rate != $past(rate))); // R6
endmodule

// File: rtl/shadow_pwm_frame.sv
module shadow_pwm_frame
    import shadow_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [DATA_W-1:0] width_q,
    input  logic [DATA_W-1:0] frame_q,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] act_width,
    output logic [DATA_W-1:0] act_frame
);
    logic wrap;
    assign wrap = tick && (cnt == act_frame);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            act_width <= '0;
            act_frame <= '1;
        end else if (!run) begin
            cnt       <= '0;
            act_width <= width_q;
            act_frame <= frame_q;
        end else if (wrap) begin
            cnt       <= '0;
            act_width <= width_q;
            act_frame <= frame_q;
        end else if (tick) begin
            cnt <= cnt + DATA_W'(1);
        end
    end

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= act_frame)); // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> (!run || ($stable(act_frame) && $stable(act_width)))); // R7
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import shadow_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        wait_i,
    input  logic        stop_i,
    output logic        pwm_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] width_q;
    logic [DATA_W-1:0] frame_q;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] act_width;
    logic [DATA_W-1:0] act_frame;
    logic              tick;

    shadow_pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .width_q (width_q),
        .frame_q (frame_q)
    );

    shadow_pwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .hold (stop_i),
        .rate (ctrl.rate),
        .tick (tick)
    );

    shadow_pwm_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .tick      (tick),
        .width_q   (width_q),
        .frame_q   (frame_q),
        .cnt       (cnt),
        .act_width (act_width),
        .act_frame (act_frame)
    );

    logic in_pulse;
    assign in_pulse = (cnt < act_width);

    always_comb begin
        if (!ctrl.run) pwm_o = 1'b1;
        else           pwm_o = in_pulse ? ctrl.pol : !ctrl.pol;
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> pwm_o); // R5
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stop_i && ctrl.run) |=> (!ctrl.run || $stable(cnt))); // R9
    AST_WAIT_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (wait_i && ctrl.run && !stop_i && ctrl.rate == '0) |-> tick); // R10
endmodule

// File: tb/shadow_pwm_tb_top.sv
module shadow_pwm_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wait_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       pwm_o;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_pwm dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wait_i(wait_i), .stop_i(stop_i), .pwm_o(pwm_o)
    );

    function automatic logic [7:0] ctl(input bit run, input bit pol, input int rate);
        return {4'(rate), 2'b00, pol, run};
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int frame, input int width);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'(frame));
        wr(2'd1, 8'(width));
    endtask

    task automatic expect_pat(input string tag, input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            chk(tag, pwm_o, pat[i]);
        end
    endtask

    task automatic t_reset_defaults;
        chk("R1 output high in reset", pwm_o, 1'b1);
        @(negedge clk); rst = 1'b0;
        chk("R1 output high after reset", pwm_o, 1'b1);
        wr(2'd0, ctl(1, 0, 0));
        for (int i = 0; i <= 384; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h80; end
            if (i == 4) wr_en = 1'b0;
            if (i == 10)  chk("R1 default width 0 keeps output high", pwm_o, 1'b1);
            if (i == 255) chk("R1 R7 old width until 0xFF frame ends", pwm_o, 1'b1);
            if (i == 256) chk("R1 R7 new width from frame 2", pwm_o, 1'b0);
            if (i == 383) chk("R2 R3 last active step", pwm_o, 1'b0);
            if (i == 384) chk("R2 R3 first inactive step", pwm_o, 1'b1);
        end
    endtask

    task automatic t_basic;
        setup(3, 2);
        wr(2'd0, ctl(1, 0, 0));
        expect_pat("R2 R3 R8 frame 4 width 2", 8, 32'hCC);
    endtask

    task automatic t_polarity;
        setup(3, 2);
        wr(2'd0, ctl(1, 1, 0));
        expect_pat("R4 inverted polarity", 8, 32'h33);
    endtask

    task automatic t_edges;
        setup(3, 0);
        wr(2'd0, ctl(1, 0, 0));
        expect_pat("R3 width 0 inactive", 8, 32'hFF);
        setup(3, 5);
        wr(2'd0, ctl(1, 0, 0));
        expect_pat("R3 width above frame active", 8, 32'h00);
    endtask

    task automatic t_disable;
        setup(3, 2);
        wr(2'd0, ctl(1, 1, 0));
        wr(2'd0, ctl(0, 1, 0));
        expect_pat("R5 disabled idle high", 6, 32'h3F);
    endtask

    task automatic t_rate;
        setup(1, 1);
        wr(2'd0, ctl(1, 0, 2));
        expect_pat("R6 rate 2 four cycles per step", 16, 32'hF0F0);
    endtask

    task automatic t_shadow;
        logic [15:0] pat = 16'hAAF0;
        setup(7, 4);
        wr(2'd0, ctl(1, 0, 0));
        for (int i = 0; i < 16; i++) begin
            if (i > 0) @(negedge clk);
            chk("R7 period and width latch at boundary", pwm_o, pat[i]);
            if (i == 1) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd1; end
            if (i == 2) begin wr_addr = 2'd1; wr_data = 8'd1; end
            if (i == 3) wr_en = 1'b0;
        end
    endtask

    task automatic t_ignored_addr;
        setup(3, 2);
        wr(2'd3, 8'hFF);
        wr(2'd0, ctl(1, 0, 0));
        expect_pat("R8 address 3 ignored", 8, 32'hCC);
    endtask

    task automatic t_stop;
        logic [11:0] pat = 12'hF00;
        setup(7, 3);
        wr(2'd0, ctl(1, 0, 0));
        for (int i = 0; i < 12; i++) begin
            if (i > 0) @(negedge clk);
            chk("R9 stop freezes phase", pwm_o, pat[i]);
            if (i == 2) stop_i = 1'b1;
            if (i == 7) stop_i = 1'b0;
        end
    endtask

    task automatic t_wait;
        setup(3, 2);
        wait_i = 1'b1;
        wr(2'd0, ctl(1, 0, 0));
        expect_pat("R10 wait has no effect", 8, 32'hCC);
        wait_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_defaults();
        t_basic();
        t_polarity();
        t_edges();
        t_disable();
        t_rate();
        t_shadow();
        t_ignored_addr();
        t_stop();
        t_wait();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule